// File: doc/BRIEF.md
# NAND Page Spare-Area Splitter

This block sits behind a NAND flash reader and receives the raw byte stream of one or more erase blocks. Each page arrives as its main-data bytes followed at once by that page's spare bytes. The block walks through every page by byte position. Main-data bytes go out on a byte stream with a valid/ready handshake. The bytes that hold the error-correction code go out on a second stream, each one tagged with the 512-byte sector of the page it protects. All other spare bytes are discarded.

The error-correction bytes do not sit at the head or tail of the spare area. They form four separate 10-byte runs, so the routing is decided for each byte offset. The first spare byte of the first page of every block is the factory bad-block marker. It is reported on a strobe so that a consumer can decide whether the block is good before it uses the block's data. Page and block boundaries are reported as single-cycle pulses.

With the default parameters a page is 2048 + 64 = 2112 bytes and a block has 64 pages. The consumer must hold back either stream's ready to stall the input. The block does not compute or check the code and does not drive NAND bus timing.

Top module: `nand_spare_splitter`

## Requirements
- R1: Page offsets 0 to MAIN_BYTES-1 (0–2047 by default) go out on the main stream in arrival order. Nothing else goes out on that stream.
- R2: The error-correction runs are at spare offsets 6–15, 22–31, 38–47 and 54–63. Bytes at those offsets go out on the code stream, and the byte at spare offset 6+16k+j (j = 0..9) carries sector tag k. Sector k covers main bytes 512k to 512k+511.
- R3: Every other spare offset is dropped and raises neither valid. This includes 0–5, 16–21, 32–37 and 48–53, so the misplaced layout with runs at 7, 17, 27 and 37 is not decoded: offsets 16, 17, 32, 33 and 37 are dropped.
- R4: in_ready is high exactly when both main_ready and ecc_ready are high. The byte and page position advance only on a cycle with in_valid and in_ready both high.
- R5: main_valid is high only for a main-data byte with in_valid and ecc_ready high. ecc_valid is high only for a code byte with in_valid and main_ready high. The two are never high together.
- R6: page_done pulses in the cycle in which the last spare byte of a page (offset 2111 by default) is accepted.
- R7: block_done pulses together with page_done for the last page of a block (page 63 by default), and at no other time.
- R8: mark_valid pulses when spare offset 0 of page 0 of each block is accepted, and at no other time. mark_bad is then 1 if that byte differs from 0xFF and 0 if it equals 0xFF.
- R9: A synchronous reset clears the byte and page position, so the next accepted byte is treated as page 0, offset 0.
- R10: main_data and ecc_data equal in_data unchanged whenever their valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Raw NAND byte present |
| in_data | input | DATA_W | Raw NAND byte |
| in_ready | output | 1 | Raw byte accepted this cycle when in_valid is high |
| main_valid | output | 1 | Main-data byte present |
| main_data | output | DATA_W | Main-data byte |
| main_ready | input | 1 | Main-stream consumer can take a byte |
| ecc_valid | output | 1 | Error-correction byte present |
| ecc_data | output | DATA_W | Error-correction byte |
| ecc_sector | output | SECT_W | Index of the sector the byte protects |
| ecc_ready | input | 1 | Code-stream consumer can take a byte |
| page_done | output | 1 | Last byte of a page accepted |
| block_done | output | 1 | Last byte of the last page of a block accepted |
| mark_valid | output | 1 | Bad-block marker byte accepted |
| mark_bad | output | 1 | Marker differs from the good value 0xFF |

## Verification
The bench sweeps every byte offset of every page in a reduced configuration, with both ready inputs held back in a pseudo-random pattern. Around each run edge it targets offsets 5/6, 15/16, 16/17 and 63. A decoder built for the misplaced layout, or one that is off by one at a run edge, would route a dropped byte into the code stream or give a wrong sector tag. The stalls show whether a design lets its position advance, or raises a valid, while the other consumer is not ready; such a design would shift every later byte by one. The bench varies the marker byte on the first page (good, zero, one bit off from 0xFF) and also checks that later pages never raise it. It resets the block part way through a page to show that the next byte is taken as offset 0 of page 0.

// File: rtl/nand_split_pkg.sv
package nand_split_pkg;

   // Routing class of one byte position within a page
   typedef enum logic [1:0] {
      BYTE_MAIN = 2'd0,
      BYTE_ECC  = 2'd1,
      BYTE_DROP = 2'd2
   } byte_class_e;

endpackage

// File: rtl/nand_page_cursor.sv
// Byte-in-page and page-in-block position; advances once per accepted byte.
module nand_page_cursor #(
   parameter int PAGE_BYTES      = 2112,
   parameter int PAGES_PER_BLOCK = 64,
   localparam int BW = $clog2(PAGE_BYTES),
   localparam int PW = $clog2(PAGES_PER_BLOCK)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step,
   output logic [BW-1:0] byte_idx,
   output logic [PW-1:0] page_idx,
   output logic          last_byte,
   output logic          last_page
);

   assign last_byte = (byte_idx == BW'(PAGE_BYTES - 1));
   assign last_page = (page_idx == PW'(PAGES_PER_BLOCK - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         byte_idx <= '0;
         page_idx <= '0;
      end else if (step) begin
         if (last_byte) begin
            byte_idx <= '0;
            page_idx <= last_page ? '0 : page_idx + PW'(1);
         end else begin
            byte_idx <= byte_idx + BW'(1);
         end
      end
   end

endmodule

// File: rtl/nand_spare_decode.sv
// Maps a byte position to main / code / drop, and a code run to its sector.
module nand_spare_decode
   import nand_split_pkg::*;
#(
   parameter int MAIN_BYTES  = 2048,
   parameter int ECC_RUNS    = 4,
   parameter int ECC_RUN_LEN = 10,
   parameter int ECC_FIRST   = 6,
   parameter int ECC_STRIDE  = 16,
   parameter int BW          = 12,
   parameter int SECT_W      = 2
) (
   input  logic [BW-1:0]     byte_idx,
   output byte_class_e       cls,
   output logic [SECT_W-1:0] sector
);

   logic                in_spare;
   logic [BW-1:0]       spare_off;
   logic [ECC_RUNS-1:0] run_hit;

   assign in_spare  = (byte_idx >= BW'(MAIN_BYTES));
   assign spare_off = byte_idx - BW'(MAIN_BYTES);

   // One window comparator per code run
   for (genvar k = 0; k < ECC_RUNS; k++) begin : g_run
      localparam int LO = ECC_FIRST + k * ECC_STRIDE;
      localparam int HI = LO + ECC_RUN_LEN;
      assign run_hit[k] = in_spare && (spare_off >= BW'(LO)) && (spare_off < BW'(HI));
   end

   always_comb begin
      sector = '0;
      for (int k = 0; k < ECC_RUNS; k++) begin
         if (run_hit[k]) sector = SECT_W'(k);
      end
   end

   always_comb begin
      if (!in_spare)     cls = BYTE_MAIN;
      else if (|run_hit) cls = BYTE_ECC;
      else               cls = BYTE_DROP;
   end

endmodule

// File: rtl/nand_spare_splitter.sv
module nand_spare_splitter
   import nand_split_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter int MAIN_BYTES      = 2048,
   parameter int SPARE_BYTES     = 64,
   parameter int SECTOR_BYTES    = 512,
   parameter int ECC_RUNS        = 4,
   parameter int ECC_RUN_LEN     = 10,
   parameter int ECC_FIRST       = 6,
   parameter int ECC_STRIDE      = 16,
   parameter int PAGES_PER_BLOCK = 64,
   parameter logic [DATA_W-1:0] GOOD_MARK = '1,
   localparam int SECT_W = $clog2(ECC_RUNS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              main_valid,
   output logic [DATA_W-1:0] main_data,
   input  logic              main_ready,
   output logic              ecc_valid,
   output logic [DATA_W-1:0] ecc_data,
   output logic [SECT_W-1:0] ecc_sector,
   input  logic              ecc_ready,
   output logic              page_done,
   output logic              block_done,
   output logic              mark_valid,
   output logic              mark_bad
);

   localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
   localparam int BW         = $clog2(PAGE_BYTES);
   localparam int PW         = $clog2(PAGES_PER_BLOCK);

   // Elaboration-time parameter checks
   initial begin
      assert (MAIN_BYTES == ECC_RUNS * SECTOR_BYTES)
         else $error("main area must be ECC_RUNS whole sectors");
      assert (ECC_FIRST + (ECC_RUNS - 1) * ECC_STRIDE + ECC_RUN_LEN <= SPARE_BYTES)
         else $error("code runs overflow the spare area");
      assert (ECC_RUN_LEN <= ECC_STRIDE) else $error("code runs overlap");
      assert (ECC_FIRST > 0) else $error("marker byte must stay outside code runs");
      assert (ECC_RUNS >= 2 && PAGES_PER_BLOCK >= 2) else $error("counts too small");
   end

   logic          fire;
   logic [BW-1:0] byte_idx;
   logic [PW-1:0] page_idx;
   logic          last_byte, last_page;
   byte_class_e   cls;

   nand_page_cursor #(
      .PAGE_BYTES     (PAGE_BYTES),
      .PAGES_PER_BLOCK(PAGES_PER_BLOCK)
   ) cursor_i (
      .clk      (clk),
      .rst      (rst),
      .step     (fire),
      .byte_idx (byte_idx),
      .page_idx (page_idx),
      .last_byte(last_byte),
      .last_page(last_page)
   );

   nand_spare_decode #(
      .MAIN_BYTES (MAIN_BYTES),
      .ECC_RUNS   (ECC_RUNS),
      .ECC_RUN_LEN(ECC_RUN_LEN),
      .ECC_FIRST  (ECC_FIRST),
      .ECC_STRIDE (ECC_STRIDE),
      .BW         (BW),
      .SECT_W     (SECT_W)
   ) decode_i (
      .byte_idx(byte_idx),
      .cls     (cls),
      .sector  (ecc_sector)
   );

   // Either consumer stalls the whole stream so positions never drift
   assign in_ready = main_ready & ecc_ready;
   assign fire     = in_valid & in_ready;

   assign main_valid = in_valid & (cls == BYTE_MAIN) & ecc_ready;
   assign ecc_valid  = in_valid & (cls == BYTE_ECC)  & main_ready;
   assign main_data  = in_data;
   assign ecc_data   = in_data;

   assign page_done  = fire & last_byte;
   assign block_done = page_done & last_page;

   assign mark_valid = fire && (page_idx == '0) && (byte_idx == BW'(MAIN_BYTES));
   assign mark_bad   = (in_data != GOOD_MARK);

endmodule

// File: rtl/nand_spare_splitter_chk.sv
module nand_spare_splitter_chk #(
   parameter int DATA_W          = 8,
   parameter int MAIN_BYTES      = 2048,
   parameter int SPARE_BYTES     = 64,
   parameter int ECC_FIRST       = 6,
   parameter int ECC_STRIDE      = 16,
   parameter int PAGES_PER_BLOCK = 64
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] in_data,
   input logic              main_valid,
   input logic              main_ready,
   input logic [DATA_W-1:0] main_data,
   input logic              ecc_valid,
   input logic              ecc_ready,
   input logic              page_done,
   input logic              block_done,
   input logic              mark_valid
);

   localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;

   int unsigned off_q;
   int unsigned page_q;

   // Independent position model driven from the port handshake (R9 reset)
   always_ff @(posedge clk) begin
      if (rst) begin
         off_q  <= 0;
         page_q <= 0;
      end else if (in_valid && in_ready) begin
         if (off_q == PAGE_BYTES - 1) begin
            off_q  <= 0;
            page_q <= (page_q == PAGES_PER_BLOCK - 1) ? 0 : page_q + 1;
         end else begin
            off_q <= off_q + 1;
         end
      end
   end

   // R1
   main_pos_chk: assert property (@(posedge clk) disable iff (rst)
      main_valid |-> off_q < MAIN_BYTES);

   // R2
   ecc_pos_chk: assert property (@(posedge clk) disable iff (rst)
      ecc_valid |-> (off_q >= MAIN_BYTES + ECC_FIRST) &&
                    (((off_q - MAIN_BYTES) % ECC_STRIDE) >= ECC_FIRST));

   // R3
   drop_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (off_q >= MAIN_BYTES && ((off_q - MAIN_BYTES) % ECC_STRIDE) < ECC_FIRST)
         |-> !main_valid && !ecc_valid);

   // R4
   main_stall_chk: assert property (@(posedge clk) disable iff (rst)
      (main_valid && !main_ready) |-> !in_ready);

   // R4
   ecc_stall_chk: assert property (@(posedge clk) disable iff (rst)
      (ecc_valid && !ecc_ready) |-> !in_ready);

   // R5
   one_stream_chk: assert property (@(posedge clk) disable iff (rst)
      !(main_valid && ecc_valid));

   // R5
   valid_src_chk: assert property (@(posedge clk) disable iff (rst)
      (main_valid || ecc_valid) |-> in_valid);

   // R6
   page_done_chk: assert property (@(posedge clk) disable iff (rst)
      page_done |-> in_valid && in_ready && off_q == PAGE_BYTES - 1);

   // R7
   block_done_chk: assert property (@(posedge clk) disable iff (rst)
      block_done |-> page_done && page_q == PAGES_PER_BLOCK - 1);

   // R8
   mark_pos_chk: assert property (@(posedge clk) disable iff (rst)
      mark_valid |-> off_q == MAIN_BYTES && page_q == 0 && !main_valid && !ecc_valid);

   // R10
   pass_chk: assert property (@(posedge clk) disable iff (rst)
      main_valid |-> main_data == in_data);

endmodule

bind nand_spare_splitter nand_spare_splitter_chk #(
   .DATA_W         (DATA_W),
   .MAIN_BYTES     (MAIN_BYTES),
   .SPARE_BYTES    (SPARE_BYTES),
   .ECC_FIRST      (ECC_FIRST),
   .ECC_STRIDE     (ECC_STRIDE),
   .PAGES_PER_BLOCK(PAGES_PER_BLOCK)
) chk_i (.*);

// File: tb/nand_spare_splitter_tb.sv
module nand_spare_splitter_tb_top;

   localparam int MB   = 64;   // reduced main area: 4 sectors of 16
   localparam int SB   = 64;   // full-size spare area
   localparam int PB   = MB + SB;
   localparam int PPB  = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_ready;
   logic       main_valid, ecc_valid;
   logic [7:0] main_data, ecc_data;
   logic [1:0] ecc_sector;
   logic       main_ready = 1'b1, ecc_ready = 1'b1;
   logic       page_done, block_done, mark_valid, mark_bad;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk = ~clk;

   nand_spare_splitter #(
      .MAIN_BYTES(MB), .SPARE_BYTES(SB), .SECTOR_BYTES(16),
      .PAGES_PER_BLOCK(PPB)
   ) dut_i (.*);

   task automatic chk(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] dat(input int blk, input int pg, input int off);
      if (off == MB && pg == 0)
         return (blk == 0) ? 8'hFF : (blk == 1) ? 8'h00 : 8'hFE;
      return 8'((blk * 101 + pg * 37 + off * 5 + 3) & 255);
   endfunction

   // Drive one byte until accepted; inputs change and checks run between edges
   task automatic send(input int blk, input int pg, input int off, input bit rnd);
      logic [7:0] d;
      bit acc;
      int s, k;
      bit is_ecc;
      d = dat(blk, pg, off);
      s = off - MB;
      is_ecc = (off >= MB) && (s >= 6) && (((s - 6) % 16) < 10);
      k = is_ecc ? (s - 6) / 16 : 0;
      in_valid = 1'b1;
      in_data  = d;
      do begin
         if (rnd) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            main_ready = lfsr[0] | lfsr[1];
            ecc_ready  = lfsr[2] | lfsr[3];
         end else begin
            main_ready = 1'b1;
            ecc_ready  = 1'b1;
         end
         #1;
         acc = main_ready && ecc_ready;
         chk("R4 in_ready", int'(in_ready), int'(acc));
         if (off < MB) begin
            chk("R1 main_valid", int'(main_valid), int'(ecc_ready));
            if (main_valid) chk("R10 main_data", int'(main_data), int'(d));
            chk("R5 ecc_valid on main byte", int'(ecc_valid), 0);
         end else if (is_ecc) begin
            chk("R2 ecc_valid", int'(ecc_valid), int'(main_ready));
            chk("R2 ecc_sector", int'(ecc_sector), k);
            chk("R10 ecc_data", int'(ecc_data), int'(d));
            chk("R5 main_valid on code byte", int'(main_valid), 0);
         end else begin
            chk("R3 dropped main_valid", int'(main_valid), 0);
            chk("R3 dropped ecc_valid", int'(ecc_valid), 0);
         end
         chk("R6 page_done", int'(page_done), int'(acc && off == PB - 1));
         chk("R7 block_done", int'(block_done), int'(acc && off == PB - 1 && pg == PPB - 1));
         chk("R8 mark_valid", int'(mark_valid), int'(acc && pg == 0 && off == MB));
         if (acc && pg == 0 && off == MB)
            chk("R8 mark_bad", int'(mark_bad), int'(d != 8'hFF));
         @(negedge clk);
      end while (!acc);
      in_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         main_ready = lfsr[4];
         ecc_ready  = lfsr[5];
         #1;
         chk("R4 idle main_valid", int'(main_valid), 0);
         chk("R4 idle ecc_valid", int'(ecc_valid), 0);
         chk("R4 idle page_done", int'(page_done), 0);
         chk("R4 idle mark_valid", int'(mark_valid), 0);
         @(negedge clk);
      end
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      #1;
      chk("R9 reset main_valid", int'(main_valid), 0);
      chk("R9 reset ecc_valid", int'(ecc_valid), 0);
      chk("R9 reset page_done", int'(page_done), 0);
      @(negedge clk);
      rst = 1'b0;
      // Two full blocks under random back-pressure
      for (int b = 0; b < 2; b++)
         for (int p = 0; p < PPB; p++)
            for (int o = 0; o < PB; o++) begin
               send(b, p, o, 1'b1);
               if (o % 37 == 0) idle(2);
            end
      // Partial page, then reset mid-page (R9)
      for (int o = 0; o < 50; o++) send(2, 0, o, 1'b1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      // Next byte must be page 0 offset 0 again: full block with no stalls
      for (int p = 0; p < PPB; p++)
         for (int o = 0; o < PB; o++)
            send(2, p, o, 1'b0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule